// File: doc/BRIEF.md
# Rotating Execution-Pipe Selector

This block chooses one free unit out of a group of up to `W` execution pipes. Each pipe is one bit of a mask. The block keeps a rotation sequence mask, and the current choice is always the highest bit still in that sequence. Units that are passed over or reported as consumed leave the sequence. When the sequence runs dry it is reloaded, so that successive choices spread across the group.

A caller raises `sel_req` together with the mask of units that are free in that cycle. One cycle later the block returns a one-hot `pick_mask` with `pick_vld`. The block does not take the chosen unit out of the sequence by itself. The caller reports each consumed unit through `used_vld`/`used_mask`, the same path it uses for units consumed by some other selector.

A unit reported as consumed while it lies numerically above the whole remaining sequence is deferred. It stays out of the next reload and returns on the reload after that. The member set is either a plain range of units or derived from a group mask.

Top module: `rps_top`

## Requirements
- R1: After reset, `pick_vld` and `sel_err` are 0, `pick_mask` is 0, the sequence equals the member set and the deferred set is empty.
- R2: With `IS_GROUP`=0 the member set is all `W` low bits. With `IS_GROUP`=1 it is `GROUP_MASK` with its highest set bit removed (for example 5'b10101 gives 4'b0101). No unit outside the member set is ever picked.
- R3: On a request with at least one ready member, the pick is found by walking down from the highest sequence bit. Every bit walked past that is not ready is cleared from the sequence. The first ready bit is returned one-hot in `pick_mask`, with `pick_vld`=1, in the cycle after the request.
- R4: A request does not remove the picked unit from the sequence, so an identical request with no consumption in between returns the same unit.
- R5: Whenever a clear leaves the sequence empty, the sequence is reloaded with member set XOR deferred set, and the deferred set is emptied.
- R6: A used report whose mask, read as an unsigned number, exceeds the current sequence is added to the deferred set and leaves the sequence unchanged. Any other used report clears its bit from the sequence, with the reload rule of R5.
- R7: A request whose ready mask has no member bit raises `sel_err` for one cycle, keeps `pick_vld` at 0 and `pick_mask` unchanged, and leaves the sequence untouched.
- R8: When a request and a used report occur in the same cycle, the request's walk is applied first and the used report is applied to the sequence that results.
- R9: In a cycle with no request, the next cycle shows `pick_vld`=0 and `sel_err`=0, and `pick_mask` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the caller |
| sel_req | input | 1 | Request a selection this cycle |
| ready_mask | input | W | Units free this cycle |
| used_vld | input | 1 | A consumed-unit report is present |
| used_mask | input | W | One-hot mask of the consumed unit |
| pick_vld | output | 1 | `pick_mask` carries a new choice |
| pick_mask | output | W | One-hot chosen unit, held between choices |
| sel_err | output | 1 | The previous request had no ready member |

## Verification
The bench builds two copies with `W`=4. One copy uses the plain member set 4'b1111, where the full rotation, the skip-driven reload and the deferral of a unit reported above the remaining sequence can all be walked by hand. The other copy uses group mask 5'b10101, which gives the sparse member set 4'b0101. There a ready mask holding only non-members must give an error, and a reload must bring back only the two member bits.

// File: rtl/rps_pkg.sv
package rps_pkg;
  // Outcome of one cycle of the selector, registered in the top module.
  typedef enum logic [1:0] {
    RPS_IDLE  = 2'd0,
    RPS_HIT   = 2'd1,
    RPS_FAULT = 2'd2
  } rps_res_e;
endpackage

// File: rtl/rps_step.sv
// One step of the unrolled candidate walk: try the highest sequence bit.
module rps_step #(
  parameter int            W    = 4,
  parameter logic [W-1:0]  FULL = '1
) (
  input  logic [W-1:0] seq_i,
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] ready_i,
  input  logic         found_i,
  input  logic [W-1:0] pick_i,
  output logic [W-1:0] seq_o,
  output logic [W-1:0] rem_o,
  output logic         found_o,
  output logic [W-1:0] pick_o
);
  logic [W-1:0] cand;

  always_comb begin
    cand = '0;
    for (int b = 0; b < W; b++) begin
      if (seq_i[b]) begin
        cand    = '0;
        cand[b] = 1'b1;
      end
    end
  end

  always_comb begin
    seq_o   = seq_i;
    rem_o   = rem_i;
    found_o = found_i;
    pick_o  = pick_i;
    if (!found_i) begin
      if ((cand & ready_i) != '0) begin
        found_o = 1'b1;
        pick_o  = cand;
      end else begin
        seq_o = seq_i & ~cand;
        if (seq_o == '0) begin
          seq_o = FULL ^ rem_i;
          rem_o = '0;
        end
      end
    end
  end
endmodule

// File: rtl/rps_search.sv
// Chain of walk steps. Three passes over W bits cover two reloads.
module rps_search #(
  parameter int           W    = 4,
  parameter logic [W-1:0] FULL = '1
) (
  input  logic [W-1:0] seq_i,
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] ready_i,
  output logic [W-1:0] seq_o,
  output logic [W-1:0] rem_o,
  output logic         found_o,
  output logic [W-1:0] pick_o
);
  localparam int STEPS = 3 * W;

  logic [W-1:0] seq_c   [0:STEPS];
  logic [W-1:0] rem_c   [0:STEPS];
  logic [W-1:0] pick_c  [0:STEPS];
  logic         found_c [0:STEPS];

  assign seq_c[0]   = seq_i;
  assign rem_c[0]   = rem_i;
  assign pick_c[0]  = '0;
  assign found_c[0] = 1'b0;

  for (genvar s = 0; s < STEPS; s++) begin : g_step
    rps_step #(.W(W), .FULL(FULL)) u_step (
      .seq_i   (seq_c[s]),
      .rem_i   (rem_c[s]),
      .ready_i (ready_i),
      .found_i (found_c[s]),
      .pick_i  (pick_c[s]),
      .seq_o   (seq_c[s+1]),
      .rem_o   (rem_c[s+1]),
      .found_o (found_c[s+1]),
      .pick_o  (pick_c[s+1])
    );
  end

  assign seq_o   = seq_c[STEPS];
  assign rem_o   = rem_c[STEPS];
  assign found_o = found_c[STEPS];
  assign pick_o  = pick_c[STEPS];
endmodule

// File: rtl/rps_notify.sv
// Applies a consumed-unit report to the sequence and deferred set.
module rps_notify #(
  parameter int           W    = 4,
  parameter logic [W-1:0] FULL = '1
) (
  input  logic         used_vld,
  input  logic [W-1:0] used_mask,
  input  logic [W-1:0] seq_i,
  input  logic [W-1:0] rem_i,
  output logic [W-1:0] seq_o,
  output logic [W-1:0] rem_o
);
  always_comb begin
    seq_o = seq_i;
    rem_o = rem_i;
    if (used_vld) begin
      if (used_mask > seq_i) begin
        rem_o = rem_i | used_mask;
      end else begin
        seq_o = seq_i & ~used_mask;
        if (seq_o == '0) begin
          seq_o = FULL ^ rem_i;
          rem_o = '0;
        end
      end
    end
  end
endmodule

// File: rtl/rps_top.sv
module rps_top
  import rps_pkg::*;
#(
  parameter int         W          = 4,
  parameter bit         IS_GROUP   = 1'b0,
  parameter logic [W:0] GROUP_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_req,
  input  logic [W-1:0] ready_mask,
  input  logic         used_vld,
  input  logic [W-1:0] used_mask,
  output logic         pick_vld,
  output logic [W-1:0] pick_mask,
  output logic         sel_err
);
  function automatic logic [W-1:0] group_members();
    logic [W:0] g;
    logic       done;
    g    = GROUP_MASK;
    done = 1'b0;
    for (int b = W; b >= 0; b--) begin
      if (!done && g[b]) begin
        g[b] = 1'b0;
        done = 1'b1;
      end
    end
    return g[W-1:0];
  endfunction

  localparam logic [W-1:0] MEMBERS = IS_GROUP ? group_members() : {W{1'b1}};

  logic [W-1:0] member_set;
  assign member_set = MEMBERS;

  // State registers
  logic [W-1:0] seq_q, seq_d;
  logic [W-1:0] rem_q, rem_d;
  rps_res_e     res_q, res_d;
  logic [W-1:0] pick_q, pick_d;
  logic         pick_en;

  // Walk
  logic [W-1:0] eff_ready;
  logic         sel_ok;
  logic [W-1:0] srch_seq, srch_rem, srch_pick;
  logic         srch_found;
  logic [W-1:0] mid_seq, mid_rem;

  assign eff_ready = ready_mask & MEMBERS;
  assign sel_ok    = sel_req && (eff_ready != '0);

  rps_search #(.W(W), .FULL(MEMBERS)) u_search (
    .seq_i   (seq_q),
    .rem_i   (rem_q),
    .ready_i (eff_ready),
    .seq_o   (srch_seq),
    .rem_o   (srch_rem),
    .found_o (srch_found),
    .pick_o  (srch_pick)
  );

  // Request first, then the used report on the result.
  always_comb begin
    mid_seq = seq_q;
    mid_rem = rem_q;
    if (sel_ok) begin
      mid_seq = srch_seq;
      mid_rem = srch_rem;
    end
  end

  rps_notify #(.W(W), .FULL(MEMBERS)) u_notify (
    .used_vld  (used_vld),
    .used_mask (used_mask),
    .seq_i     (mid_seq),
    .rem_i     (mid_rem),
    .seq_o     (seq_d),
    .rem_o     (rem_d)
  );

  always_comb begin
    res_d   = RPS_IDLE;
    pick_d  = srch_pick;
    pick_en = 1'b0;
    if (sel_req) begin
      if (sel_ok && srch_found) begin
        res_d   = RPS_HIT;
        pick_en = 1'b1;
      end else begin
        res_d = RPS_FAULT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= MEMBERS;
      rem_q  <= '0;
      res_q  <= RPS_IDLE;
      pick_q <= '0;
    end else begin
      seq_q <= seq_d;
      rem_q <= rem_d;
      res_q <= res_d;
      if (pick_en) begin
        pick_q <= pick_d;
      end
    end
  end

  assign pick_vld  = (res_q == RPS_HIT);
  assign sel_err   = (res_q == RPS_FAULT);
  assign pick_mask = pick_q;
endmodule

// File: rtl/rps_chk.sv
module rps_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sel_req,
  input logic [W-1:0] ready_mask,
  input logic         pick_vld,
  input logic [W-1:0] pick_mask,
  input logic         sel_err,
  input logic [W-1:0] member_set
);
  assert_pick_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld |-> ($countones(pick_mask) == 1));

  assert_pick_member_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld |-> ((pick_mask & ~member_set) == '0));

  assert_pick_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld |-> ((pick_mask & $past(ready_mask)) != '0));

  assert_hit_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_req && ((ready_mask & member_set) != '0)) |=> (pick_vld && !sel_err));

  assert_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_req && ((ready_mask & member_set) == '0)) |=>
      (sel_err && !pick_vld && $stable(pick_mask)));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_req |=> (!pick_vld && !sel_err && $stable(pick_mask)));

  assert_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(pick_vld && sel_err));
endmodule

bind rps_top rps_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_req    (sel_req),
  .ready_mask (ready_mask),
  .pick_vld   (pick_vld),
  .pick_mask  (pick_mask),
  .sel_err    (sel_err),
  .member_set (member_set)
);

// File: tb/sim_rps_top.sv
`timescale 1ns/1ps
module sim_rps_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       sreq [2];
  logic [3:0] rdy  [2];
  logic       uvld [2];
  logic [3:0] umsk [2];
  logic       pv   [2];
  logic [3:0] pm   [2];
  logic       er   [2];

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  rps_top #(.W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_req(sreq[0]), .ready_mask(rdy[0]),
    .used_vld(uvld[0]), .used_mask(umsk[0]),
    .pick_vld(pv[0]), .pick_mask(pm[0]), .sel_err(er[0]));

  rps_top #(.W(4), .IS_GROUP(1'b1), .GROUP_MASK(5'b10101)) u1 (
    .clk(clk), .rst_n(rst_n), .sel_req(sreq[1]), .ready_mask(rdy[1]),
    .used_vld(uvld[1]), .used_mask(umsk[1]),
    .pick_vld(pv[1]), .pick_mask(pm[1]), .sel_err(er[1]));

  // Drive one cycle at a negedge, return at the next negedge with idle inputs.
  task automatic cyc(input int d, input logic s, input logic [3:0] r,
                     input logic uv, input logic [3:0] um);
    sreq[d] = s; rdy[d] = r; uvld[d] = uv; umsk[d] = um;
    @(negedge clk);
    sreq[d] = 1'b0; rdy[d] = '0; uvld[d] = 1'b0; umsk[d] = '0;
  endtask

  task automatic chk(input int d, input logic ev, input logic [3:0] em,
                     input logic ee, input string tag);
    n_chk++;
    if (pv[d] !== ev || pm[d] !== em || er[d] !== ee) begin
      n_bad++;
      $display("FAIL %s dut%0d: vld=%b mask=%b err=%b expected vld=%b mask=%b err=%b",
               tag, d, pv[d], pm[d], er[d], ev, em, ee);
    end
  endtask

  task automatic sel(input int d, input logic [3:0] r, input logic [3:0] em,
                     input string tag);
    cyc(d, 1'b1, r, 1'b0, 4'b0000);
    chk(d, 1'b1, em, 1'b0, tag);
  endtask

  task automatic used(input int d, input logic [3:0] m);
    cyc(d, 1'b0, 4'b0000, 1'b1, m);
  endtask

  task automatic t_reset();
    chk(0, 1'b0, 4'b0000, 1'b0, "R1 reset plain");
    chk(1, 1'b0, 4'b0000, 1'b0, "R1 reset group");
  endtask

  task automatic t_basic();
    sel(0, 4'b1111, 4'b1000, "R3 highest first");
    sel(0, 4'b1111, 4'b1000, "R4 pick not consumed");
  endtask

  task automatic t_rotate();
    used(0, 4'b1000);
    sel(0, 4'b1111, 4'b0100, "R6 used clears bit");
    used(0, 4'b0100);
    sel(0, 4'b1111, 4'b0010, "R6 rotation");
    used(0, 4'b0010);
    sel(0, 4'b1111, 4'b0001, "R6 rotation low");
    used(0, 4'b0001);
    chk(0, 1'b0, 4'b0001, 1'b0, "R9 idle holds");
    sel(0, 4'b1111, 4'b1000, "R5 reload after empty");
  endtask

  task automatic t_skip();
    sel(0, 4'b0011, 4'b0010, "R3 skip not ready");
    sel(0, 4'b0001, 4'b0001, "R3 skip continues");
    sel(0, 4'b1000, 4'b1000, "R5 reload during walk");
  endtask

  task automatic t_defer();
    used(0, 4'b1000);
    used(0, 4'b0100);
    used(0, 4'b1000);
    sel(0, 4'b1111, 4'b0010, "R6 above-sequence deferred");
    used(0, 4'b0010);
    used(0, 4'b0001);
    sel(0, 4'b1111, 4'b0100, "R5 deferred excluded from reload");
    used(0, 4'b0100);
    used(0, 4'b0010);
    used(0, 4'b0001);
    sel(0, 4'b1111, 4'b1000, "R5 deferred set emptied");
  endtask

  task automatic t_error();
    cyc(0, 1'b1, 4'b0000, 1'b0, 4'b0000);
    chk(0, 1'b0, 4'b1000, 1'b1, "R7 empty ready");
    sel(0, 4'b1111, 4'b1000, "R7 state unchanged");
  endtask

  task automatic t_both();
    cyc(0, 1'b1, 4'b1111, 1'b1, 4'b1000);
    chk(0, 1'b1, 4'b1000, 1'b0, "R8 request with used");
    sel(0, 4'b1111, 4'b0100, "R8 used applied after walk");
  endtask

  task automatic t_group();
    sel(1, 4'b1111, 4'b0100, "R2 group highest member");
    used(1, 4'b0100);
    sel(1, 4'b1111, 4'b0001, "R2 group next member");
    cyc(1, 1'b1, 4'b1010, 1'b0, 4'b0000);
    chk(1, 1'b0, 4'b0001, 1'b1, "R7 non-member ready");
    used(1, 4'b0001);
    sel(1, 4'b1111, 4'b0100, "R2 group reload");
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin
      sreq[d] = 1'b0; rdy[d] = '0; uvld[d] = 1'b0; umsk[d] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_rotate();
    t_skip();
    t_defer();
    t_error();
    t_both();
    t_group();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule